// File: doc/BRIEF.md
# Strap-Configured Audio Clock Master

This block produces the serial bit clock and the left/right frame clock of a two-channel audio serial port from a master clock. It works in one clock domain, which is the master clock. After reset it waits a fixed number of master-clock cycles so that the pin levels can settle. It then takes one snapshot of three strap levels and of a fast-clock select. The strap on the data-output pin picks master or slave operation. The strap on the frame-clock pin picks single or double sample rate. The strap on the bit-clock pin picks between the binary ratio family (128x/256x/512x) and the ternary family (192x/384x/768x).

In master mode the two clock pins drive outputs once the snapshot is taken. In slave mode they stay undriven. The bit clock always runs at 64 periods per frame. When the master clock is the fast variant for the chosen rate, an internal divide-by-two applies, so the output clocks have the same rate as with the slow variant.

A pad ring uses the output-enable pair to drive the clock pins. It uses the latched status bits to configure the rest of the converter.

Top module: `acm_clock_master`

## Requirements
- R1: The outputs `cfg_valid_o`, `bclk_oe_o` and `lrclk_oe_o` are 0 during reset and until SETTLE_CYCLES rising master-clock edges have passed since reset release. `cfg_valid_o` becomes 1 on exactly that edge. In master mode both enables also become 1 on that edge.
- R2: A strap level of 1 on `strap_data_i` selects master mode, and `master_o` reads 1. A level of 0 selects slave mode: `master_o` reads 0, both enables stay 0, and `bclk_o` and `lrclk_o` stay 0.
- R3: A strap level of 0 on `strap_frame_i` selects single rate. A level of 1 selects double rate. `dbl_speed_o` reports the latched level.
- R4: A strap level of 0 on `strap_bit_i` selects the binary family. A level of 1 selects the ternary family. `alt_family_o` reports the latched level.
- R5: With `mclk_fast_i` at 0, the bit-clock period in master-clock cycles is 4 for single/binary (256x), 6 for single/ternary (384x), 2 for double/binary (128x) and 3 for double/ternary (192x).
- R6: With `mclk_fast_i` at 1 when the snapshot is taken, every bit-clock period and high time is exactly twice its R5/R10 value (512x, 768x, 256x and 384x).
- R7: The frame-clock period is 64 bit-clock periods. `lrclk_o` is 0 for the first 32 bits after enable and 1 for the next 32 bits.
- R8: `lrclk_o` changes only on the master-clock edge where `bclk_o` goes from 1 to 0.
- R9: The straps and the fast select are sampled only once. Changes after the snapshot do not affect the status outputs or the clock periods.
- R10: `bclk_o` is 0 when the enables rise. Its high time is floor(P/2) internal ticks out of a period of P ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Master clock |
| rst_n_i | input | 1 | Active-low asynchronous reset |
| strap_data_i | input | 1 | Level on the data-output pin during settling (1 = master) |
| strap_frame_i | input | 1 | Level on the frame-clock pin during settling (1 = double rate) |
| strap_bit_i | input | 1 | Level on the bit-clock pin during settling (1 = ternary family) |
| mclk_fast_i | input | 1 | Master clock is the fast variant (divide by two) |
| bclk_o | output | 1 | Bit clock value for the pad |
| lrclk_o | output | 1 | Frame clock value for the pad |
| bclk_oe_o | output | 1 | Drive enable for the bit-clock pad |
| lrclk_oe_o | output | 1 | Drive enable for the frame-clock pad |
| cfg_valid_o | output | 1 | Strap snapshot taken |
| master_o | output | 1 | Latched master/slave choice |
| dbl_speed_o | output | 1 | Latched rate choice |
| alt_family_o | output | 1 | Latched ratio family |

## Verification
The bench places its enable checks on the edges just before and just after the end of the settling count. A counter that is off by one would turn the pins into outputs while the straps are still being read, or one cycle late. It covers the odd three-tick divider, where a wrong half-period split gives the wrong high time or drifts the period. It also covers the fast-clock variants, where a missing divide-by-two gives clocks at twice the intended rate. Each run is watched for frame-clock changes that do not coincide with a bit-clock fall, which would mean a misaligned frame. Straps are toggled after the snapshot and slave mode is selected: a design that samples the straps continuously, or that drives the pins as a slave, would show up in the status bits and the enables.

// File: rtl/acm_pkg.sv
package acm_pkg;

   typedef enum logic {
      SPD_SINGLE = 1'b0,
      SPD_DOUBLE = 1'b1
   } speed_e;

   typedef enum logic {
      FAM_BINARY  = 1'b0,
      FAM_TERNARY = 1'b1
   } family_e;

   typedef struct packed {
      logic    master;
      speed_e  speed;
      family_e family;
      logic    mclk_fast;
   } strap_cfg_t;

   // internal ticks per bit-clock period at 64 bits per frame
   localparam int unsigned TICKS_SINGLE = 4;
   localparam int unsigned TICKS_MAX    = TICKS_SINGLE * 3 / 2;
   localparam int unsigned TICK_W       = $clog2(TICKS_MAX + 1);

   function automatic logic [TICK_W-1:0] bit_ticks(speed_e spd, family_e fam);
      int unsigned base;
      base = (spd == SPD_SINGLE) ? TICKS_SINGLE : TICKS_SINGLE / 2;
      if (fam == FAM_TERNARY) base = base * 3 / 2;
      return TICK_W'(base);
   endfunction

endpackage

// File: rtl/acm_strap_latch.sv
module acm_strap_latch
   import acm_pkg::*;
#(
   parameter int unsigned SETTLE_CYCLES = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       data_lvl_i,
   input  logic       frame_lvl_i,
   input  logic       bit_lvl_i,
   input  logic       fast_i,
   output strap_cfg_t cfg_o,
   output logic       valid_o
);
   localparam int unsigned CNT_W = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

   generate
      if (SETTLE_CYCLES < 1) begin : g_bad_settle
         $error("SETTLE_CYCLES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         valid_o <= 1'b0;
         cfg_o   <= '{master: 1'b0, speed: SPD_SINGLE, family: FAM_BINARY, mclk_fast: 1'b0};
      end else if (!valid_o) begin
         if (cnt_q == LAST) begin
            valid_o <= 1'b1;
            cfg_o   <= '{master:    data_lvl_i,
                         speed:     speed_e'(frame_lvl_i),
                         family:    family_e'(bit_lvl_i),
                         mclk_fast: fast_i};
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/acm_tick_gen.sv
module acm_tick_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic fast_i,
   output logic tick_o
);
   logic ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ph_q <= 1'b0;
      else if (!run_i) ph_q <= 1'b0;
      else             ph_q <= ~ph_q;
   end

   assign tick_o = run_i & (~fast_i | ph_q);

endmodule

// File: rtl/acm_clk_gen.sv
module acm_clk_gen
   import acm_pkg::*;
#(
   parameter int unsigned FRAME_BITS = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic              tick_i,
   input  logic [TICK_W-1:0] ticks_i,
   output logic              bclk_o,
   output logic              lrclk_o
);
   localparam int unsigned BC_W = $clog2(FRAME_BITS);

   generate
      if (FRAME_BITS < 4 || (FRAME_BITS & (FRAME_BITS - 1)) != 0) begin : g_bad_frame
         $error("FRAME_BITS must be a power of two, at least 4");
      end
   endgenerate

   logic [TICK_W-1:0] pc_q, pc_n, hi_start;
   logic [BC_W-1:0]   bc_q, bc_n;
   logic              wrap;

   assign hi_start = ticks_i - (ticks_i >> 1);
   assign wrap     = (pc_q == ticks_i - 1'b1);
   assign pc_n     = wrap ? '0 : pc_q + 1'b1;
   assign bc_n     = wrap ? bc_q + 1'b1 : bc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= '0; bc_q <= '0; bclk_o <= 1'b0; lrclk_o <= 1'b0;
      end else if (!run_i) begin
         pc_q <= '0; bc_q <= '0; bclk_o <= 1'b0; lrclk_o <= 1'b0;
      end else if (tick_i) begin
         pc_q    <= pc_n;
         bc_q    <= bc_n;
         bclk_o  <= (pc_n >= hi_start);
         lrclk_o <= bc_n[BC_W-1];
      end
   end

endmodule

// File: rtl/acm_clock_master.sv
module acm_clock_master
   import acm_pkg::*;
#(
   parameter int unsigned SETTLE_CYCLES = 16,
   parameter int unsigned FRAME_BITS    = 64
) (
   input  logic mclk_i,
   input  logic rst_n_i,
   input  logic strap_data_i,
   input  logic strap_frame_i,
   input  logic strap_bit_i,
   input  logic mclk_fast_i,
   output logic bclk_o,
   output logic lrclk_o,
   output logic bclk_oe_o,
   output logic lrclk_oe_o,
   output logic cfg_valid_o,
   output logic master_o,
   output logic dbl_speed_o,
   output logic alt_family_o
);
   strap_cfg_t        cfg;
   logic              valid, run, tick;
   logic [TICK_W-1:0] ticks;

   acm_strap_latch #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_latch (
      .clk(mclk_i), .rst_n(rst_n_i),
      .data_lvl_i(strap_data_i), .frame_lvl_i(strap_frame_i),
      .bit_lvl_i(strap_bit_i), .fast_i(mclk_fast_i),
      .cfg_o(cfg), .valid_o(valid)
   );

   assign run   = valid & cfg.master;
   assign ticks = bit_ticks(cfg.speed, cfg.family);

   acm_tick_gen u_tick (
      .clk(mclk_i), .rst_n(rst_n_i), .run_i(run),
      .fast_i(cfg.mclk_fast), .tick_o(tick)
   );

   acm_clk_gen #(.FRAME_BITS(FRAME_BITS)) u_gen (
      .clk(mclk_i), .rst_n(rst_n_i), .run_i(run), .tick_i(tick),
      .ticks_i(ticks), .bclk_o(bclk_o), .lrclk_o(lrclk_o)
   );

   assign bclk_oe_o    = run;
   assign lrclk_oe_o   = run;
   assign cfg_valid_o  = valid;
   assign master_o     = cfg.master;
   assign dbl_speed_o  = (cfg.speed == SPD_DOUBLE);
   assign alt_family_o = (cfg.family == FAM_TERNARY);

endmodule

// File: rtl/acm_clock_master_chk.sv
module acm_clock_master_chk (
   input logic mclk_i,
   input logic rst_n_i,
   input logic bclk_o,
   input logic lrclk_o,
   input logic bclk_oe_o,
   input logic lrclk_oe_o,
   input logic cfg_valid_o,
   input logic master_o,
   input logic dbl_speed_o,
   input logic alt_family_o
);
   AST_NO_DRIVE_BEFORE_SNAPSHOT: assert property (@(posedge mclk_i) disable iff (!rst_n_i)
      !cfg_valid_o |-> (!bclk_oe_o && !lrclk_oe_o)); // R1

   AST_SLAVE_UNDRIVEN: assert property (@(posedge mclk_i) disable iff (!rst_n_i)
      (cfg_valid_o && !master_o) |-> (!bclk_oe_o && !bclk_o && !lrclk_o)); // R2

   AST_STATUS_FROZEN: assert property (@(posedge mclk_i) disable iff (!rst_n_i)
      (cfg_valid_o && $past(cfg_valid_o)) |-> $stable({master_o, dbl_speed_o, alt_family_o})); // R9

   AST_FRAME_ON_BIT_FALL: assert property (@(posedge mclk_i) disable iff (!rst_n_i)
      (lrclk_oe_o && $past(lrclk_oe_o) && (lrclk_o != $past(lrclk_o))) |-> $fell(bclk_o)); // R8

   AST_VALID_STICKY: assert property (@(posedge mclk_i) disable iff (!rst_n_i)
      $past(cfg_valid_o) |-> cfg_valid_o); // R1

   AST_START_LOW: assert property (@(posedge mclk_i) disable iff (!rst_n_i)
      $rose(bclk_oe_o) |-> (!bclk_o && !lrclk_o)); // R10
endmodule

bind acm_clock_master acm_clock_master_chk u_chk (
   .mclk_i(mclk_i), .rst_n_i(rst_n_i), .bclk_o(bclk_o), .lrclk_o(lrclk_o),
   .bclk_oe_o(bclk_oe_o), .lrclk_oe_o(lrclk_oe_o), .cfg_valid_o(cfg_valid_o),
   .master_o(master_o), .dbl_speed_o(dbl_speed_o), .alt_family_o(alt_family_o)
);

// File: tb/acm_clock_master_bench.sv
`timescale 1ns/1ps
module acm_clock_master_bench;
   localparam int SETTLE = 16;

   typedef struct packed {
      logic dbl; logic alt; logic fast;
      logic [7:0] per; logic [7:0] hi;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{1'b0, 1'b0, 1'b0, 8'd4,  8'd2},   // R5 single binary 256x
      '{1'b0, 1'b1, 1'b0, 8'd6,  8'd3},   // R5 single ternary 384x
      '{1'b1, 1'b0, 1'b0, 8'd2,  8'd1},   // R5 double binary 128x
      '{1'b1, 1'b1, 1'b0, 8'd3,  8'd1},   // R5 double ternary 192x
      '{1'b0, 1'b0, 1'b1, 8'd8,  8'd4},   // R6 512x
      '{1'b0, 1'b1, 1'b1, 8'd12, 8'd6},   // R6 768x
      '{1'b1, 1'b0, 1'b1, 8'd4,  8'd2},   // R6 256x
      '{1'b1, 1'b1, 1'b1, 8'd6,  8'd2}    // R6 384x
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic s_data = 1'b0, s_frame = 1'b0, s_bit = 1'b0, fast = 1'b0;
   logic bclk, lrclk, bclk_oe, lrclk_oe, cfg_valid, master, dbl, alt;
   int errors = 0, checks = 0;

   always #2 clk = ~clk;

   acm_clock_master #(.SETTLE_CYCLES(SETTLE), .FRAME_BITS(64)) u_acm_clock_master (
      .mclk_i(clk), .rst_n_i(rst_n), .strap_data_i(s_data), .strap_frame_i(s_frame),
      .strap_bit_i(s_bit), .mclk_fast_i(fast), .bclk_o(bclk), .lrclk_o(lrclk),
      .bclk_oe_o(bclk_oe), .lrclk_oe_o(lrclk_oe), .cfg_valid_o(cfg_valid),
      .master_o(master), .dbl_speed_o(dbl), .alt_family_o(alt)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   // reset, hold straps, release; returns at the negedge where the snapshot is visible
   task automatic boot(input logic sd, input logic sf, input logic sb, input logic fs);
      @(negedge clk);
      rst_n = 1'b0; s_data = sd; s_frame = sf; s_bit = sb; fast = fs;
      repeat (3) @(negedge clk);
      check(!cfg_valid && !bclk_oe && !lrclk_oe, "R1 reset state", {cfg_valid, bclk_oe}, 0);
      rst_n = 1'b1;
      repeat (SETTLE - 1) @(negedge clk);
      check(!cfg_valid && !bclk_oe && !lrclk_oe, "R1 before settle", {cfg_valid, bclk_oe}, 0);
      @(negedge clk);
      check(cfg_valid === 1'b1, "R1 valid at settle", cfg_valid, 1);
      check(bclk_oe === sd && lrclk_oe === sd, "R1/R2 enables at settle", bclk_oe, sd);
   endtask

   task automatic run_window(input int n, output int per, output int hi,
                             output int lr_per, output int lr_bits, output int misalign);
      logic pb, pl, b, l;
      int last_rise, last_lr, bits;
      per = -1; hi = -1; lr_per = -1; lr_bits = -1; misalign = 0;
      last_rise = -1; last_lr = -1; bits = 0;
      pb = bclk; pl = lrclk;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         b = bclk; l = lrclk;
         if (l != pl && !(pb && !b)) misalign++;
         if (b && !pb) begin
            if (last_rise >= 0) per = i - last_rise;
            last_rise = i;
            if (l) bits++;
         end
         if (!b && pb && last_rise >= 0) hi = i - last_rise;
         if (l && !pl) begin
            if (last_lr >= 0) lr_per = i - last_lr;
            last_lr = i; bits = 0;
         end
         if (!l && pl && last_lr >= 0) lr_bits = bits;
         pb = b; pl = l;
      end
   endtask

   initial begin
      int per, hi, lrp, lrb, mis;
      for (int v = 0; v < 8; v++) begin
         boot(1'b1, VECS[v].dbl, VECS[v].alt, VECS[v].fast);
         check(master === 1'b1, "R2 master status", master, 1);
         check(dbl === VECS[v].dbl, "R3 rate status", dbl, VECS[v].dbl);
         check(alt === VECS[v].alt, "R4 family status", alt, VECS[v].alt);
         check(!bclk && !lrclk, "R10 start low", {bclk, lrclk}, 0);
         run_window(3 * 64 * int'(VECS[v].per) + 20, per, hi, lrp, lrb, mis);
         check(per == int'(VECS[v].per), VECS[v].fast ? "R6 bclk period" : "R5 bclk period",
               per, VECS[v].per);
         check(hi == int'(VECS[v].hi), "R10 bclk high time", hi, VECS[v].hi);
         check(lrp == 64 * int'(VECS[v].per), "R7 frame period", lrp, 64 * VECS[v].per);
         check(lrb == 32, "R7 bits per half frame", lrb, 32);
         check(mis == 0, "R8 frame change off bit fall", mis, 0);
      end

      // R9: straps and fast select flipped after the snapshot
      boot(1'b1, 1'b0, 1'b0, 1'b0);
      s_data = 1'b0; s_frame = 1'b1; s_bit = 1'b1; fast = 1'b1;
      run_window(3 * 64 * 4 + 20, per, hi, lrp, lrb, mis);
      check(master && !dbl && !alt, "R9 status after strap change", {master, dbl, alt}, 3'b100);
      check(per == 4, "R9 period after strap change", per, 4);
      check(bclk_oe === 1'b1, "R9 enable kept", bclk_oe, 1);

      // R2: slave mode never drives
      boot(1'b0, 1'b1, 1'b1, 1'b0);
      check(master === 1'b0 && dbl && alt, "R2 slave status", {master, dbl, alt}, 3'b011);
      begin
         int toggles = 0;
         for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (bclk || lrclk || bclk_oe || lrclk_oe) toggles++;
         end
         check(toggles == 0, "R2 slave outputs idle", toggles, 0);
      end

      finish_run();
   end
endmodule